// File: doc/BRIEF.md
# Interrupt Output Hold-Off Controller

This block drives one interrupt request pin from a vector of already-enabled internal request sources and one wake-event source. When the pin drops, the controller can keep it low for a programmable hold-off time, counted in 10 µs steps. This gives the host time to finish its handler before the next request reaches it. A 10 µs tick is made from the clock frequency parameter `CLK_HZ`. The hold-off length is the programmed step count times `CLK_HZ/100000` clock cycles.

Software uses a single 32-bit control/status word. It sets the step count and the pin enable. It can restart a hold-off at any time, or cancel it by writing a zero step count. It can also read whether a hold-off is running and whether any source is requesting. The wake-event source is exempt from the hold-off. The pin is registered, so it follows its inputs one clock later.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: After reset every field reads 0 and the pin is low. The step count sits in bits 31:24 and reads back as written. Bits 23:15, 11:9 and 7:0 always read 0, whatever is written to them.
- R2: When the pin falls while no hold-off runs and the step count is non-zero, a hold-off starts on the next cycle. It lasts exactly count × `CLK_HZ/100000` cycles, and bit 13 reads 1 for exactly those cycles.
- R3: The pin is the registered value of: enable AND ((any source request AND no hold-off running) OR wake request). A request that is held back reaches the pin one cycle after the hold-off ends.
- R4: A write with bit 14 = 1 and a non-zero step count starts a fresh hold-off of the written length, even if a hold-off is already running. Bit 14 always reads 0.
- R5: A write with step count 0 ends any hold-off at that clock edge, so bit 13 reads 0 on the next cycle and a pending request reaches the pin one cycle later. This takes precedence over bit 14.
- R6: Writing a new non-zero step count while a hold-off runs does not change the remaining length of that hold-off. Only later hold-offs use the new count.
- R7: Bit 12 reads the OR of the source requests in the same cycle, whatever the enable and the hold-off state.
- R8: With the enable (bit 8) at 0 the pin stays low. Bits 12 and 13 behave as with the enable at 1.
- R9: A wake request drives the pin high one cycle later while the enable is 1, even during a hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Enabled interrupt source requests |
| wake_req | input | 1 | Wake-event request, exempt from hold-off |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control/status word read value |
| irq_o | output | 1 | Interrupt request pin, active high |

## Verification
The hardest cases to reach are the interactions inside a running hold-off. These are a restart or cancel that lands in mid-interval, a count rewrite that must not re-time the current interval, and a wake pulse that must cut through. The bench reaches each of them with a directed sequence that first makes the pin fall to open a hold-off and then writes at chosen offsets. A long random phase follows, with short step counts and a fast tick. It checks every cycle against a remaining-cycles model, so writes, source edges and wake pulses fall on every prescaler phase.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
  localparam int REG_W       = 32;
  localparam int IVL_W       = 8;
  localparam int IVL_LSB     = 24;
  localparam int RESTART_BIT = 14;
  localparam int BUSY_BIT    = 13;
  localparam int RAW_BIT     = 12;
  localparam int EN_BIT      = 8;
  localparam int unsigned STEP_HZ = 100_000;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sync_clr_i,
  output logic tick_o
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (sync_clr_i)  cnt_d = '0;
    else if (run_i)  cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_presc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_presc_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel_i,
  input  logic             load_i,
  input  logic [IVL_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             active_o
);
  logic             active_q, active_d;
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic [IVL_W-1:0] lim_q, lim_d;

  assign active_o = active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    lim_d    = lim_q;
    if (cancel_i) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (load_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
      lim_d    = load_val_i;
    end else if (active_q && tick_i) begin
      if (cnt_q == lim_q - 1'b1) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      lim_q    <= lim_d;
    end
  end

  assert_cnt_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < lim_q));
  assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (load_val_i != '0));
  assert_cancel_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !active_q);
  assert_load_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !cancel_i) |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl
  import irq_holdoff_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int          NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               wake_req,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq_o
);
  localparam int unsigned STEP_CYC = (CLK_HZ / STEP_HZ > 0) ? CLK_HZ / STEP_HZ : 1;

  logic [IVL_W-1:0] ivl_q, ivl_d;
  logic             en_q, en_d;
  logic             irq_q, irq_d;
  logic             raw_irq, hold_act, tick;
  logic [IVL_W-1:0] wr_ivl;
  logic             cancel, restart, start, load, pin_fall;
  logic [IVL_W-1:0] load_val;
  logic             unused_wbits;

  assign wr_ivl       = reg_wdata[IVL_LSB +: IVL_W];
  assign unused_wbits = ^{reg_wdata[IVL_LSB-1:RESTART_BIT+1],
                          reg_wdata[RESTART_BIT-1:EN_BIT+1], reg_wdata[EN_BIT-1:0]};
  assign raw_irq      = |src_req;

  // Pin request and hold-off triggers
  assign irq_d    = en_q & ((raw_irq & ~hold_act) | wake_req);
  assign pin_fall = irq_q & ~irq_d;
  assign cancel   = reg_wr & (wr_ivl == '0);
  assign restart  = reg_wr & reg_wdata[RESTART_BIT] & (wr_ivl != '0);
  assign start    = pin_fall & ~hold_act & (ivl_q != '0);
  assign load     = restart | start;
  assign load_val = restart ? wr_ivl : ivl_q;

  always_comb begin
    ivl_d = ivl_q;
    en_d  = en_q;
    if (reg_wr) begin
      ivl_d = wr_ivl;
      en_d  = reg_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ivl_q <= ivl_d;
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  irq_tick_gen #(.PERIOD(STEP_CYC)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (hold_act),
    .sync_clr_i (cancel | load),
    .tick_o     (tick)
  );

  irq_holdoff_timer #(.IVL_W(IVL_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cancel_i   (cancel),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .active_o   (hold_act)
  );

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[IVL_LSB +: IVL_W]      = ivl_q;
    reg_rdata[BUSY_BIT]              = hold_act;
    reg_rdata[RAW_BIT]               = raw_irq;
    reg_rdata[EN_BIT]                = en_q;
  end

  assign irq_o = irq_q;

  assert_pin_off_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_o);
  assert_holdoff_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !wake_req) |=> !irq_o);
  assert_wake_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wake_req) |=> irq_o);
  assert_fall_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_d && !hold_act && ivl_q != '0 && !cancel) |=> hold_act);
endmodule

// File: tb/irq_holdoff_ctrl_tb.sv
module irq_holdoff_ctrl_tb;
  localparam int unsigned CLK_HZ = 400_000;
  localparam int T = CLK_HZ / 100_000;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic wake = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int m_rem;
  logic [7:0] m_ivl;
  logic m_en, m_pin;

  always #5 clk = ~clk;

  irq_holdoff_ctrl #(.CLK_HZ(CLK_HZ), .NUM_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src), .wake_req(wake),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  function automatic logic [31:0] mk(input logic [7:0] ivl, input logic clr, input logic en);
    return {ivl, 9'b0, clr, 5'b0, en, 8'b0};
  endfunction

  function automatic logic [31:0] exp_rd();
    return {m_ivl, 9'b0, 1'b0, (m_rem != 0), |src, 3'b0, m_en, 8'b0};
  endfunction

  // remaining-cycles model of the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem <= 0; m_ivl <= '0; m_en <= 1'b0; m_pin <= 1'b0;
    end else begin
      logic nxt;
      nxt = m_en & (((|src) & (m_rem == 0)) | wake);
      if (wr && wdata[31:24] == 0)           m_rem <= 0;
      else if (wr && wdata[14])              m_rem <= int'(wdata[31:24]) * T;
      else if (m_pin && !nxt && m_rem == 0 && m_ivl != 0) m_rem <= int'(m_ivl) * T;
      else if (m_rem > 0)                    m_rem <= m_rem - 1;
      if (wr) begin m_ivl <= wdata[31:24]; m_en <= wdata[8]; end
      m_pin <= nxt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // check current outputs, then apply the next inputs
  task automatic cyc(input string tag, input logic w, input logic [31:0] d,
                     input logic [NS-1:0] s, input logic wk);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, m_pin});
    chk("R2", {31'b0, rdata[13]}, {31'b0, m_rem != 0});
    chk("R7", {31'b0, rdata[12]}, {31'b0, |src});
    chk("R1", rdata, exp_rd());
    wr = w; wdata = d; src = s; wake = wk;
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    chk("R1", rdata, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    // program count 3, enable, junk in reserved bits (R1)
    cyc("R1", 1, mk(8'd3, 0, 1) | 32'h00A0_2E05, '0, 0);
    cyc("R1", 0, '0, 4'b0010, 0);
    repeat (3) cyc("R3", 0, '0, 4'b0010, 0);
    // pin falls: hold-off of 12 cycles opens (R2)
    repeat (2) cyc("R2", 0, '0, 4'b0000, 0);
    repeat (3) cyc("R3", 0, '0, 4'b1000, 0);
    // rewrite count mid-interval: no re-timing (R6)
    cyc("R6", 1, mk(8'd6, 0, 1), 4'b1000, 0);
    repeat (14) cyc("R6", 0, '0, 4'b1000, 0);
    // fall again, then restart mid-interval (R4)
    cyc("R2", 0, '0, 4'b0000, 0);
    repeat (5) cyc("R2", 0, '0, 4'b0100, 0);
    cyc("R4", 1, mk(8'd2, 1, 1), 4'b0100, 0);
    repeat (4) cyc("R4", 0, '0, 4'b0100, 0);
    // wake cuts through the hold-off (R9)
    repeat (3) cyc("R9", 0, '0, 4'b0100, 1);
    cyc("R9", 0, '0, 4'b0100, 0);
    repeat (3) cyc("R9", 0, '0, 4'b0100, 0);
    // cancel with count 0, overrides restart bit (R5)
    cyc("R5", 1, mk(8'd0, 1, 1), 4'b0100, 0);
    repeat (4) cyc("R5", 0, '0, 4'b0100, 0);
    // disable pin (R8)
    cyc("R8", 1, mk(8'd2, 0, 0), 4'b0100, 1);
    repeat (6) cyc("R8", 0, '0, 4'b0101, 1);
    cyc("R8", 0, '0, 4'b0000, 0);
    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      logic w;
      logic [31:0] d;
      logic [NS-1:0] s;
      logic wk;
      w  = ($urandom % 16) == 0;
      d  = mk(8'($urandom % 6), ($urandom % 3) == 0, ($urandom % 8) != 0)
           | ($urandom & 32'h00FF_BEFF);
      s  = (($urandom % 4) == 0) ? NS'($urandom) : src;
      wk = ($urandom % 24) == 0;
      cyc("R3", w, d, s, wk);
    end
    cyc("R3", 0, '0, '0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule